// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a 128-entry byte register space. The system clock oversamples the bus lines. SCL and SDA each pass through a two-flop synchronizer, and the block looks for edges on the synchronized copies. It recognises START, repeated START and STOP conditions and answers only to device address 7'b0011101. After an addressed write header it accepts a sub-address byte. The low seven bits of that byte load a register pointer, and the top bit selects whether the pointer steps forward after every data byte.

Write data follows the sub-address in the same direction of transfer. Each received byte produces a one-clock write strobe on a simple register port. A read starts as a write header plus sub-address. A repeated START and the address with the read bit set follow. The slave then shifts out register contents, MSB first, for as long as the master acknowledges. SDA is never driven high: `sdaOe` high means the pin is pulled low.

Top module: `regbus_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) moves the slave to address reception from any state. A STOP (SDA rising while SCL is high) returns it to idle. In both cases `sdaOe` is released. After reset `sdaOe` and `regWrEn` are low.
- R2: The first byte after a START is a 7-bit address (MSB first) followed by a direction bit (1 = master reads, 0 = master writes). The slave pulls SDA low for the ninth clock only when the address equals 7'b0011101. For any other address it leaves SDA released for every clock until the next START or STOP.
- R3: The byte after an addressed write header is acknowledged. Its bits [6:0] load the register pointer, and its bit 7 set enables auto-increment.
- R4: Every write data byte is acknowledged. `regWrEn` pulses high for exactly one clock per byte, with `regAddr` equal to the pointer and `regWrData` equal to the byte.
- R5: With auto-increment on, the pointer advances by one after each data byte, written or read, and wraps from 127 to 0.
- R6: With auto-increment off, every data byte of one transfer writes or reads the same register.
- R7: After a repeated START and the address with the read bit set, the slave sends the register at the stored pointer, MSB first.
- R8: A master acknowledge (SDA low on the ninth clock of a read byte) makes the slave send the next byte. A master not-acknowledge leaves SDA released until the next START or STOP.
- R9: The slave changes `sdaOe` only after a detected SCL falling edge, or when it releases SDA on a START or STOP. It never changes `sdaOe` while SCL is high.
- R10: A START that arrives in the middle of a data byte discards the partial byte without issuing a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | 7 | Register pointer presented to the register port |
| regWrEn | output | 1 | One-clock write strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Contents of register `regAddr` |

## Verification
The bench sweeps all 128 device addresses. A slave that decodes the address wrongly would acknowledge a foreign address or keep answering after a mismatch. It writes and reads the whole register space in a single auto-incrementing transfer that starts mid-space, so a pointer that saturates or misses the 127-to-0 wrap corrupts the second half. Fixed-pointer transfers catch a design that steps the pointer when it should not. A read that ends with a not-acknowledge catches a slave that keeps driving data. A START cut into a half-sent byte catches a design that writes the leftover bits. A monitor watches for `sdaOe` moving while SCL is high, which would look like a false START or STOP on the bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_SUB, ST_WR, ST_RD, ST_IGNORE
  } busState_t;

  // One-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic shiftIn;    // capture sampled SDA into the receive byte
    logic loadSub;    // load pointer and auto-increment flag
    logic writeData;  // emit register write strobe
    logic advance;    // step pointer if auto-increment is on
    logic txLoad;     // fetch read byte and drive its MSB
    logic shiftTx;    // drive next transmit bit
    logic ackDrive;   // pull SDA low for an acknowledge
    logic relSda;     // let SDA go
  } ctrlStrobe_t;
endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrobe_t       strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaSync,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sdaOe
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclNow;
  logic [BYTE_W-1:0] rxNext, txReg;
  logic [ADDR_W-1:0] addrPtr;
  logic       autoInc;

  // Synchronizers reset to the idle bus level so no edge appears at reset exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end

  assign sclNow   = sclPipe[1];
  assign sdaSync  = sdaPipe[1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaSync;
  assign rxNext   = {rxByte[BYTE_W-2:0], sdaSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      addrPtr   <= '0;
      autoInc   <= 1'b0;
      txReg     <= '0;
      sdaOe     <= 1'b0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      if (strb.shiftIn) rxByte <= rxNext;
      if (strb.loadSub) begin
        addrPtr <= rxNext[ADDR_W-1:0];
        autoInc <= rxNext[BYTE_W-1];
      end else if (strb.advance && autoInc) begin
        addrPtr <= addrPtr + 1'b1;
      end
      regWrEn <= strb.writeData;
      if (strb.writeData) regWrData <= rxNext;
      if (strb.txLoad) begin
        txReg <= regRdData;
        sdaOe <= ~regRdData[BYTE_W-1];
      end else if (strb.shiftTx) begin
        txReg <= {txReg[BYTE_W-2:0], 1'b0};
        sdaOe <= ~txReg[BYTE_W-2];
      end else if (strb.ackDrive) begin
        sdaOe <= 1'b1;
      end else if (strb.relSda) begin
        sdaOe <= 1'b0;
      end
    end
  end

  assign regAddr = addrPtr;

  // R4: write strobe is a single clock wide
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R9: the open-drain enable moves only after an SCL fall or a bus condition
  p_oe_timing_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall || startDet || stopDet));

  // R1: a STOP always leaves SDA released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaSync,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrlStrobe_t       strb
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  busState_t        state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             inAck, ackNext;
  logic             mAck, mAckNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      inAck  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      inAck  <= ackNext;
      mAck   <= mAckNext;
    end
  end

  always_comb begin
    strb     = '0;
    stNext   = state;
    cntNext  = bitCnt;
    ackNext  = inAck;
    mAckNext = mAck;
    if (stopDet || startDet) begin
      stNext      = stopDet ? ST_IDLE : ST_DEV;
      strb.relSda = 1'b1;
      cntNext     = '0;
      ackNext     = 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_SUB, ST_WR: begin
          if (sclRise && !inAck && bitCnt < FULL) begin
            strb.shiftIn = 1'b1;
            cntNext      = bitCnt + 1'b1;
            if (bitCnt == LAST) begin
              strb.loadSub   = (state == ST_SUB);
              strb.writeData = (state == ST_WR);
            end
          end else if (sclFall && !inAck && bitCnt == FULL) begin
            ackNext = 1'b1;
            if (state == ST_DEV && rxByte[BYTE_W-1:1] != DEV_ADDR)
              stNext = ST_IGNORE;
            else
              strb.ackDrive = 1'b1;
          end else if (sclFall && inAck) begin
            ackNext = 1'b0;
            cntNext = '0;
            if (state == ST_DEV && rxByte[0]) begin
              stNext      = ST_RD;
              strb.txLoad = 1'b1;
            end else begin
              stNext       = (state == ST_DEV) ? ST_SUB : ST_WR;
              strb.relSda  = 1'b1;
              strb.advance = (state == ST_WR);
            end
          end
        end
        ST_RD: begin
          if (sclRise && !inAck && bitCnt < FULL) begin
            cntNext = bitCnt + 1'b1;
          end else if (sclFall && !inAck && bitCnt == FULL) begin
            ackNext     = 1'b1;
            strb.relSda = 1'b1;
          end else if (sclFall && !inAck && bitCnt != '0) begin
            strb.shiftTx = 1'b1;
          end else if (sclRise && inAck) begin
            mAckNext     = ~sdaSync;
            strb.advance = ~sdaSync;
          end else if (sclFall && inAck) begin
            ackNext = 1'b0;
            cntNext = '0;
            if (mAck) begin
              strb.txLoad = 1'b1;
            end else begin
              stNext      = ST_IGNORE;
              strb.relSda = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1: a START without a simultaneous STOP always leads to address reception
  p_start_dev_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !stopDet) |=> (state == ST_DEV));

  // R8: a not-acknowledged read byte silences the slave
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD && inAck && !mAck && sclFall && !startDet && !stopDet)
      |=> (state == ST_IGNORE));
endmodule

// File: rtl/regbus_i2c_slave.sv
module regbus_i2c_slave
  import i2cs_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter logic [6:0] DEV_ADDR = 7'h1D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  timeunit 1ns;
  timeprecision 100ps;

  ctrlStrobe_t       strb;
  logic              sclRise, sclFall, startDet, stopDet, sdaSync;
  logic [BYTE_W-1:0] rxByte;

  i2cs_control #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaSync(sdaSync),
    .rxByte(rxByte), .strb(strb)
  );

  i2cs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .sdaSync(sdaSync), .rxByte(rxByte),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sdaOe(sdaOe)
  );
endmodule

// File: tb/regbus_i2c_slave_bench.sv
module regbus_i2c_slave_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int Q     = 6;
  localparam int LIMIT = 190000;
  localparam logic [7:0] WR_HDR = 8'h3A;
  localparam logic [7:0] RD_HDR = 8'h3B;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sdaOe, sdaLine, regWrEn;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regMem [0:127];
  logic [7:0] expMem [0:127];
  logic       memInit = 1'b0;
  int         passCnt = 0, totalCnt = 0, wrCount = 0, oeViol = 0;
  logic       prevOe = 1'b0;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = regMem[regAddr];

  regbus_i2c_slave u_regbus_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  function automatic logic [7:0] seedVal(input int i);
    return 8'((i * 29 + 7) ^ 90);
  endfunction

  always @(posedge clk) begin
    if (memInit) begin
      for (int i = 0; i < 128; i++) regMem[i] <= seedVal(i);
    end else if (regWrEn) begin
      regMem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  // R9 monitor: slave must not move SDA while SCL is high
  always @(negedge clk) begin
    if (rstN) begin
      if (sclM && sdaOe !== prevOe) oeViol = oeViol + 1;
      prevOe = sdaOe;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(1);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    acked = ~sdaLine;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] v);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      sclM = 1'b1; waitQ(1);
      v[i] = sdaLine;
      waitQ(1);
      sclM = 1'b0;
    end
    waitQ(1);
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
    sdaM = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit         ak;
    logic [7:0] rv;
    int         w0;
    for (int i = 0; i < 128; i++) expMem[i] = seedVal(i);
    memInit = 1'b1;
    repeat (4) @(negedge clk);
    memInit = 1'b0;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!sdaOe && !regWrEn, "R1 reset state", {sdaOe, regWrEn}, 0);

    // R6 / R4: fixed-pointer write of three bytes to 0x10
    w0 = wrCount;
    i2cStart();
    sendByte(WR_HDR, ak); check(ak, "R2 own address ack", ak, 1);
    sendByte(8'h10, ak);  check(ak, "R3 sub-address ack", ak, 1);
    sendByte(8'hA1, ak);  check(ak, "R4 data ack", ak, 1);
    sendByte(8'hB2, ak);  check(ak, "R4 data ack", ak, 1);
    sendByte(8'hC3, ak);  check(ak, "R4 data ack", ak, 1);
    i2cStop();
    expMem[16] = 8'hC3;
    check(wrCount - w0 == 3, "R4 one strobe per byte", wrCount - w0, 3);
    check(regMem[16] == 8'hC3, "R6 same register", regMem[16], 8'hC3);
    check(regMem[17] == expMem[17], "R6 neighbour untouched", regMem[17], expMem[17]);
    check(!sdaOe, "R1 released after stop", sdaOe, 0);

    // R5: auto-increment write across the 127 -> 0 wrap
    i2cStart();
    sendByte(WR_HDR, ak);
    sendByte(8'hFE, ak);
    for (int k = 0; k < 4; k++) begin
      sendByte(8'(8'hD0 + k), ak);
      expMem[(126 + k) % 128] = 8'(8'hD0 + k);
    end
    i2cStop();
    for (int k = 0; k < 4; k++)
      check(regMem[(126 + k) % 128] == expMem[(126 + k) % 128], "R5 wrap write",
            regMem[(126 + k) % 128], expMem[(126 + k) % 128]);

    // R7 / R8 / R5: read with wrap, then a not-acknowledge
    i2cStart();
    sendByte(WR_HDR, ak);
    sendByte(8'hFF, ak);
    i2cStart();
    sendByte(RD_HDR, ak); check(ak, "R7 read header ack", ak, 1);
    recvByte(1'b1, rv); check(rv == expMem[127], "R7 first read byte", rv, expMem[127]);
    recvByte(1'b1, rv); check(rv == expMem[0], "R8 ack gives next byte", rv, expMem[0]);
    recvByte(1'b0, rv); check(rv == expMem[1], "R5 read increment", rv, expMem[1]);
    recvByte(1'b0, rv); check(rv == 8'hFF, "R8 quiet after nack", rv, 8'hFF);
    i2cStop();

    // R6: fixed-pointer read
    i2cStart();
    sendByte(WR_HDR, ak);
    sendByte(8'h05, ak);
    i2cStart();
    sendByte(RD_HDR, ak);
    for (int k = 0; k < 3; k++) begin
      recvByte(k < 2, rv);
      check(rv == expMem[5], "R6 repeated read", rv, expMem[5]);
    end
    i2cStop();

    // R10: START in the middle of a data byte
    w0 = wrCount;
    i2cStart();
    sendByte(WR_HDR, ak);
    sendByte(8'h20, ak);
    for (int k = 0; k < 4; k++) sendBit(k[0]);
    i2cStart();
    i2cStop();
    check(wrCount == w0, "R10 no strobe for partial byte", wrCount - w0, 0);
    check(regMem[32] == expMem[32], "R10 register kept", regMem[32], expMem[32]);

    // R2: every device address
    for (int a = 0; a < 128; a++) begin
      bit ak2;
      i2cStart();
      sendByte({7'(a), 1'b0}, ak);
      sendByte(8'h00, ak2);
      i2cStop();
      check(ak == (a == 29), "R2 address ack", ak, a == 29);
      check(ak2 == (a == 29), "R2 follow-up byte ack", ak2, a == 29);
    end

    // R5 / R7: full-space write then read from 0x40 with wrap
    i2cStart();
    sendByte(WR_HDR, ak);
    sendByte(8'hC0, ak);
    for (int k = 0; k < 128; k++) begin
      sendByte(8'(k * 53 + 11), ak);
      expMem[(64 + k) % 128] = 8'(k * 53 + 11);
    end
    i2cStop();
    i2cStart();
    sendByte(WR_HDR, ak);
    sendByte(8'hC0, ak);
    i2cStart();
    sendByte(RD_HDR, ak);
    for (int k = 0; k < 128; k++) begin
      recvByte(k < 127, rv);
      check(rv == expMem[(64 + k) % 128], "R5 R7 sweep read", rv, expMem[(64 + k) % 128]);
    end
    i2cStop();

    check(oeViol == 0, "R9 SDA steady while SCL high", oeViol, 0);
    summary();
  end
endmodule